// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a two-wire bus target in front of a byte-wide memory array of 256 locations. SCL and SDA are sampled in the system clock domain through a short synchronizer, and the block pulls SDA low by raising an open-drain enable. A START (SDA falling while SCL is high) opens a transfer and a STOP (SDA rising while SCL is high) closes it. The first byte after START is matched against the fixed type nibble 1010 and three strap pins. Its lowest bit selects read (1) or write (0).

A write transfer carries one address byte and then data bytes. Each data byte lands at the address counter, and only the low four address bits advance, so a long burst wraps inside its 16-byte page. The STOP that ends a write with at least one accepted byte starts a programming window. During that window the block refuses to acknowledge its select code. A read transfer returns the byte at the address counter, MSB first. The counter advances across the whole array after each byte, for as long as the master acknowledges. A random read is an address-only write followed by a repeated START with the read flag set. A write-control pin locks the array.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: While rst_ni is low, and after its release until a matching select byte is received, sda_oe_o is low.
- R2: A select byte whose bits [7:4] are 1010 and bits [3:1] equal chip_en_i[2:0] is acknowledged: sda_oe_o is high during the ninth SCL period. sda_oe_o changes only on an SCL falling edge, a START or a STOP.
- R3: A select byte that mismatches in any of bits [7:1] is not acknowledged, and SDA stays released for the rest of the transfer until the next START.
- R4: A write of select, address and one data byte, followed by STOP, stores the byte. A later random read at that address returns it.
- R5: In a write burst the address advances only in bits [3:0]. Bytes past the end of a 16-byte page wrap to the start of the same page.
- R6: A read returns bytes MSB first. The address advances by one across the full array after each byte. The master's acknowledge fetches the next byte, and its no-acknowledge ends the read with SDA released.
- R7: A read with no preceding address byte starts at the address counter as the previous transfer left it.
- R8: While wr_ctrl_i is high, select and address bytes are acknowledged, but data bytes are not acknowledged and leave the array unchanged.
- R9: A STOP that ends a write with at least one stored byte makes the block refuse its select code for PROG_CYCLES clock cycles. After that it acknowledges again.
- R10: A STOP after an address-only write, or after a write in which every data byte was refused, starts no programming window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level as seen on the wire |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| chip_en_i | input | 3 | Strapped select bits compared with select bits [3:1] |
| wr_ctrl_i | input | 1 | High blocks all array writes |

## Verification
The bench builds the block with PROG_CYCLES set to 2000. At that value a select sent right after a write STOP falls inside the busy window, and a short idle wait is enough to see the window close, so both sides of R9 are checked in one run. All other parameters keep their defaults: an 8-bit address, 16-byte pages and two synchronizer stages. This lets page wrap and the cross-page increment of sequential reads be checked on the real array. The bus runs at 32 system clocks per bit, which leaves margin over the synchronizer delay for every SDA sample.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_ADDR, ST_ADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } ee_state_e;
  localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_s, scl_p, sda_s, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end

  assign scl_s = scl_sh[STAGES-1];
  assign scl_p = scl_sh[STAGES];
  assign sda_s = sda_sh[STAGES-1];
  assign sda_p = sda_sh[STAGES];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) arr[waddr_i] <= wdata_i;

  assign rdata_o = arr[raddr_i];
endmodule

// File: rtl/i2c_ee_timer.sv
module i2c_ee_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int PROG_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] chip_en_i,
  input  logic       wr_ctrl_i
);
  localparam logic [3:0] BYTE_END = 4'd8;

  ee_state_e         state_q;
  logic [3:0]        bitcnt_q;
  logic [7:0]        sh_q, tx_q, rdata;
  logic [ADDR_W-1:0] addr_q, page_inc;
  logic              sda_oe_q, rd_q, more_q, wr_pend_q;
  logic              sda_s, scl_rise, scl_fall, start, stop;
  logic              busy, sel_hit, mem_we, byte_done;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_ee_mem #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk_i, .we_i(mem_we), .waddr_i(addr_q), .wdata_i(sh_q),
    .raddr_i(addr_q), .rdata_o(rdata)
  );

  i2c_ee_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i, .rst_ni, .load_i(stop & wr_pend_q), .busy_o(busy)
  );

  assign byte_done = scl_fall && (bitcnt_q == BYTE_END);
  assign sel_hit   = (sh_q[7:4] == TYPE_CODE) && (sh_q[3:1] == chip_en_i) && !busy;
  assign page_inc  = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
  assign mem_we    = !start && !stop && (state_q == ST_WDATA) && byte_done && !wr_ctrl_i;
  assign sda_oe_o  = sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bitcnt_q  <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      addr_q    <= '0;
      sda_oe_q  <= 1'b0;
      rd_q      <= 1'b0;
      more_q    <= 1'b0;
      wr_pend_q <= 1'b0;
    end else if (start) begin
      state_q  <= ST_DEV;
      bitcnt_q <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop) begin
      state_q   <= ST_IDLE;
      sda_oe_q  <= 1'b0;
      wr_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && bitcnt_q != BYTE_END) begin
            sh_q     <= {sh_q[6:0], sda_s};
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (byte_done) begin
            bitcnt_q <= '0;
            if (state_q == ST_DEV) begin
              if (sel_hit) begin
                sda_oe_q <= 1'b1;
                rd_q     <= sh_q[0];
                tx_q     <= rdata;
                state_q  <= ST_DEV_ACK;
              end else begin
                state_q  <= ST_IDLE;
              end
            end else if (state_q == ST_ADDR) begin
              addr_q   <= sh_q[ADDR_W-1:0];
              sda_oe_q <= 1'b1;
              state_q  <= ST_ADDR_ACK;
            end else begin
              sda_oe_q <= !wr_ctrl_i;
              if (!wr_ctrl_i) begin
                addr_q    <= page_inc;
                wr_pend_q <= 1'b1;
              end
              state_q <= ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK, ST_ADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            if (state_q == ST_DEV_ACK && rd_q) begin
              sda_oe_q <= !tx_q[7];
              bitcnt_q <= 4'd1;
              state_q  <= ST_RDATA;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= (state_q == ST_DEV_ACK) ? ST_ADDR : ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bitcnt_q != BYTE_END) begin
              sda_oe_q <= !tx_q[6];
              tx_q     <= {tx_q[6:0], 1'b0};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else begin
              sda_oe_q <= 1'b0;
              addr_q   <= addr_q + 1'b1;
              state_q  <= ST_RACK;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            more_q <= !sda_s;
          end else if (scl_fall) begin
            if (more_q) begin
              tx_q     <= rdata;
              sda_oe_q <= !rdata[7];
              bitcnt_q <= 4'd1;
              state_q  <= ST_RDATA;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk
  import i2c_ee_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      sda_oe_o,
  input logic      wr_ctrl_i,
  input logic      scl_fall,
  input logic      start,
  input logic      stop,
  input logic      mem_we,
  input logic      busy,
  input ee_state_e state_q
);
  // R1
  always @(posedge clk_i)
    if (!rst_ni) sda_rel_in_reset_chk: assert (!sda_oe_o);

  // R2
  oe_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> $past(scl_fall || start || stop));

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o);

  // R8
  wc_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> !wr_ctrl_i);

  // R9
  busy_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (state_q != ST_DEV_ACK));
endmodule

bind i2c_eeprom_slave i2c_ee_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_o(sda_oe_o), .wr_ctrl_i(wr_ctrl_i),
  .scl_fall(scl_fall), .start(start), .stop(stop), .mem_we(mem_we),
  .busy(busy), .state_q(state_q)
);

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int Q = 8;
  localparam int PROG = 2000;
  localparam logic [7:0] WSEL = 8'hAA;
  localparam logic [7:0] RSEL = 8'hAB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, wc = 1'b0;
  logic sda_oe;
  logic sda_line;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_eeprom_slave #(.PROG_CYCLES(PROG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .chip_en_i(3'b101), .wr_ctrl_i(wc)
  );

  // {select byte, expected ack}; straps are 101
  localparam logic [8:0] SEL_VEC [6] = '{
    {8'hAA, 1'b1}, {8'hA2, 1'b0}, {8'hA8, 1'b0},
    {8'hAE, 1'b0}, {8'h2A, 1'b0}, {8'hEA, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    ack = !sda_line;
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1'b1; wq(Q); d[i] = sda_line; wq(Q); scl = 1'b0; wq(Q);
    end
    sda_m = nack; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [7:0] a);
    logic ack;
    i2c_start();
    send_byte(WSEL, ack); check("R2 select", {7'd0, ack}, 8'd1);
    send_byte(a, ack);    check("R4 address", {7'd0, ack}, 8'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    wq(3);
    check("R1 in reset", {7'd0, sda_oe}, 8'd0);
    rst_n = 1'b1; wq(4);
    check("R1 after reset", {7'd0, sda_oe}, 8'd0);

    // select-code table (R2, R3)
    foreach (SEL_VEC[k]) begin
      i2c_start();
      send_byte(SEL_VEC[k][8:1], ack);
      check(SEL_VEC[k][0] ? "R2 match" : "R3 mismatch", {7'd0, ack}, {7'd0, SEL_VEC[k][0]});
      if (!SEL_VEC[k][0]) begin
        send_byte(8'h00, ack);
        check("R3 stays silent", {7'd0, ack}, 8'd0);
      end
      i2c_stop();
    end

    // R4 byte write, R9 busy
    set_addr(8'h10);
    send_byte(8'h5C, ack); check("R4 data ack", {7'd0, ack}, 8'd1);
    i2c_stop();
    i2c_start();
    send_byte(WSEL, ack); check("R9 busy nack", {7'd0, ack}, 8'd0);
    i2c_stop();
    wq(PROG + 100);
    i2c_start();
    send_byte(WSEL, ack); check("R9 ack after window", {7'd0, ack}, 8'd1);
    i2c_stop();

    // R4 random read, R10 no window after dummy write
    set_addr(8'h10);
    i2c_start();
    send_byte(RSEL, ack); check("R4 read select", {7'd0, ack}, 8'd1);
    read_byte(1'b1, d);   check("R4 read back", d, 8'h5C);
    i2c_stop();
    i2c_start();
    send_byte(WSEL, ack); check("R10 no busy after dummy write", {7'd0, ack}, 8'd1);
    i2c_stop();

    // R5 page write wrapping at 0x2F -> 0x20
    set_addr(8'h2E);
    send_byte(8'h11, ack); check("R5 d0", {7'd0, ack}, 8'd1);
    send_byte(8'h22, ack); check("R5 d1", {7'd0, ack}, 8'd1);
    send_byte(8'h33, ack); check("R5 d2", {7'd0, ack}, 8'd1);
    send_byte(8'h44, ack); check("R5 d3", {7'd0, ack}, 8'd1);
    i2c_stop();
    wq(PROG + 100);

    // R5/R6 sequential read across wrapped bytes
    set_addr(8'h20);
    i2c_start(); send_byte(RSEL, ack);
    read_byte(1'b0, d); check("R5 wrapped 0x20", d, 8'h33);
    read_byte(1'b1, d); check("R6 next 0x21", d, 8'h44);
    check("R6 released after nack", {7'd0, sda_oe}, 8'd0);
    i2c_stop();
    set_addr(8'h2E);
    i2c_start(); send_byte(RSEL, ack);
    read_byte(1'b0, d); check("R6 0x2E", d, 8'h11);
    read_byte(1'b1, d); check("R6 0x2F", d, 8'h22);
    i2c_stop();

    // R7 current-address read: counter left at 0x30 -> use 0x2E read of one byte
    set_addr(8'h2E);
    i2c_start(); send_byte(RSEL, ack);
    read_byte(1'b1, d); check("R7 setup 0x2E", d, 8'h11);
    i2c_stop();
    i2c_start(); send_byte(RSEL, ack);
    check("R7 select", {7'd0, ack}, 8'd1);
    read_byte(1'b1, d); check("R7 current 0x2F", d, 8'h22);
    i2c_stop();

    // R8 write lock, R10 no window after refused data
    wc = 1'b1;
    set_addr(8'h10);
    send_byte(8'hFF, ack); check("R8 data nack", {7'd0, ack}, 8'd0);
    i2c_stop();
    i2c_start();
    send_byte(WSEL, ack); check("R10 no busy after refused data", {7'd0, ack}, 8'd1);
    i2c_stop();
    wc = 1'b0;
    set_addr(8'h10);
    i2c_start(); send_byte(RSEL, ack);
    read_byte(1'b1, d); check("R8 array unchanged", d, 8'h5C);
    i2c_stop();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule